// File: doc/BRIEF.md
# Write-Only Two-Wire Receiver for a Character Overlay Memory

This block is a receive-only slave on a two-wire serial bus. It watches oversampled clock and data lines and accepts write transfers sent to one fixed address. Each transfer carries a row byte and a column byte, then any number of payload bytes. Every payload byte becomes a one-cycle write strobe into a row/column overlay memory. The row byte also selects a plane, either character codes or per-character attributes. The memory itself sits outside this block.

Rows 0 to 14 hold the character grid in columns 0 to 29. Column 31 of those rows is the per-row attribute byte. Row 15 is the control bank: columns 0 to 11 are window controls (three bytes for each of four windows), columns 12 to 18 are screen controls, and columns 19 to 26 are eight pulse-width duty bytes. The block never drives the data line except to pull it low for an acknowledge. It never answers a read and never holds the clock low.

Top module: `osd_i2c_sink`

## Requirements
- R1: Only the address byte 0x7A is acknowledged. Any other address byte is not acknowledged, including the read address 0x7B. After an unacknowledged address, every byte up to the next START is neither acknowledged nor written.
- R2: The first data byte after the address sets the pointer: bits 3:0 are the row and bit 7 is the plane (0 = character code, 1 = attribute). The second data byte sets the column in bits 4:0. Neither byte produces a write.
- R3: Every later data byte produces exactly one single-cycle `wr_en` pulse carrying the current plane, row, column and byte. The column then increments modulo 32.
- R4: In rows 0 to 14, columns 0 to 29 and column 31 are written. Column 30 is discarded, but the column still advances past it.
- R5: In row 15, columns 0 to 26 are written and columns 27 to 31 are discarded. All of these bytes are still acknowledged.
- R6: Each byte that is acknowledged has `sda_oe` asserted from the SCL fall after its eighth bit until the next SCL fall. `sda_oe` is low at every other time.
- R7: A START or STOP that arrives before the eighth bit of a byte discards that byte without a write.
- R8: A repeated START restarts address matching and clears the pointer, so a new row byte and column byte are needed before any further write.
- R9: Nonzero row-byte bits 6:4, or nonzero column-byte bits 7:5, point outside the memory. All payload bytes for that pointer are acknowledged and discarded.
- R10: After reset, `sda_oe` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | High to pull the data line low (acknowledge) |
| wr_en | output | 1 | One-cycle write strobe |
| wr_plane | output | 1 | 0 = character code plane, 1 = attribute plane |
| wr_row | output | 4 | Target row |
| wr_col | output | 5 | Target column |
| wr_data | output | 8 | Byte to store |

## Verification
Two things happen in the same register update: the decision to discard a reserved location and the column increment. A byte that is thrown away must still move the pointer. The bench provokes this by streaming across column 30 and across row 15 columns 27 to 31 into a wrap to column 0. Its behavioural model advances its own column on every payload byte, whether or not it expects a write, so the column tagged on the first strobe after a discarded run shows whether the increment happened. The same overlap is tested with an abort: a START or STOP lands while a byte is half shifted in, and the bench requires that no strobe follows and that the next frame addresses fresh.

// File: rtl/osd_i2c_pkg.sv
package osd_i2c_pkg;
    localparam logic [7:0] DEV_ADDR   = 8'h7A;
    localparam int         ROW_W      = 4;
    localparam int         COL_W      = 5;
    localparam int         SYNC_STAGES = 2;
    localparam logic [ROW_W-1:0] CTRL_ROW      = ROW_W'(15);
    localparam logic [COL_W-1:0] GRID_RSVD_COL = COL_W'(30);
    localparam logic [COL_W-1:0] CTRL_LAST_COL = COL_W'(26);

    typedef enum logic [1:0] {LK_IDLE, LK_RX, LK_ACK} lnk_st_e;

    typedef struct packed {
        lnk_st_e    st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       addr_ph;
        logic       ack_pend;
        logic       oe;
        logic       vld;
    } lnk_t;

    typedef struct packed {
        logic [1:0]       idx;
        logic             plane;
        logic [ROW_W-1:0] row;
        logic             row_bad;
        logic [COL_W-1:0] col;
        logic             col_bad;
        logic             wr_en;
        logic             wr_plane;
        logic [ROW_W-1:0] wr_row;
        logic [COL_W-1:0] wr_col;
        logic [7:0]       wr_data;
    } ptr_t;
endpackage

// File: rtl/osd_i2c_sync.sv
module osd_i2c_sync
    import osd_i2c_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int N = SYNC_STAGES + 1;

    logic [N-1:0] scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[N-2:0], scl_i};
        sda_d = {sda_q[N-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_lvl   = scl_q[N-2];
    assign sda_lvl   = sda_q[N-2];
    assign scl_rise  = scl_q[N-2] & ~scl_q[N-1];
    assign scl_fall  = ~scl_q[N-2] & scl_q[N-1];
    assign bus_start = scl_q[N-2] & scl_q[N-1] & sda_q[N-1] & ~sda_q[N-2];
    assign bus_stop  = scl_q[N-2] & scl_q[N-1] & ~sda_q[N-1] & sda_q[N-2];
endmodule

// File: rtl/osd_i2c_link.sv
module osd_i2c_link
    import osd_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    output logic       sda_oe,
    output logic       byte_vld,
    output logic [7:0] byte_val
);
    lnk_t d, q;
    logic [7:0] nb;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        nb    = {q.sh[6:0], sda_lvl};
        if (bus_start) begin
            d.st       = LK_RX;
            d.cnt      = '0;
            d.addr_ph  = 1'b1;
            d.ack_pend = 1'b0;
            d.oe       = 1'b0;
        end else if (bus_stop) begin
            d.st       = LK_IDLE;
            d.ack_pend = 1'b0;
            d.oe       = 1'b0;
        end else begin
            case (q.st)
                LK_RX: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = nb;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            d.ack_pend = q.addr_ph ? (nb == DEV_ADDR) : 1'b1;
                            d.vld      = ~q.addr_ph;
                        end
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.st = q.ack_pend ? LK_ACK : LK_IDLE;
                        d.oe = q.ack_pend;
                    end
                end
                LK_ACK: begin
                    if (scl_fall) begin
                        d.st       = LK_RX;
                        d.oe       = 1'b0;
                        d.cnt      = '0;
                        d.addr_ph  = 1'b0;
                        d.ack_pend = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: LK_IDLE, cnt: '0, sh: '0, addr_ph: 1'b0,
                   ack_pend: 1'b0, oe: 1'b0, vld: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe   = q.oe;
    assign byte_vld = q.vld;
    assign byte_val = q.sh;

    AST_ACK_ONLY_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> (!q.addr_ph || q.sh == DEV_ADDR)); // R1
    AST_ACK_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !bus_start && !bus_stop) |-> $stable(q.oe)); // R6
    AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |-> (q.st == LK_RX && q.cnt == 4'd8)); // R7
endmodule

// File: rtl/osd_i2c_sink.sv
module osd_i2c_sink
    import osd_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic             wr_en,
    output logic             wr_plane,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [7:0]       wr_data
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic byte_vld;
    logic [7:0] byte_val;

    osd_i2c_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
    );

    osd_i2c_link u_link (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
        .bus_stop(bus_stop), .sda_oe(sda_oe), .byte_vld(byte_vld),
        .byte_val(byte_val)
    );

    ptr_t d, q;
    logic rsvd;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        rsvd    = (q.row == CTRL_ROW) ? (q.col > CTRL_LAST_COL)
                                      : (q.col == GRID_RSVD_COL);
        if (bus_start) begin
            d.idx = 2'd0;
        end else if (byte_vld) begin
            case (q.idx)
                2'd0: begin
                    d.plane   = byte_val[7];
                    d.row     = byte_val[ROW_W-1:0];
                    d.row_bad = |byte_val[6:ROW_W];
                    d.idx     = 2'd1;
                end
                2'd1: begin
                    d.col     = byte_val[COL_W-1:0];
                    d.col_bad = |byte_val[7:COL_W];
                    d.idx     = 2'd2;
                end
                default: begin
                    d.wr_en    = ~(rsvd | q.row_bad | q.col_bad);
                    d.wr_plane = q.plane;
                    d.wr_row   = q.row;
                    d.wr_col   = q.col;
                    d.wr_data  = byte_val;
                    d.col      = q.col + COL_W'(1);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en    = q.wr_en;
    assign wr_plane = q.wr_plane;
    assign wr_row   = q.wr_row;
    assign wr_col   = q.wr_col;
    assign wr_data  = q.wr_data;

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3
    AST_NO_GRID_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_row != CTRL_ROW) |-> (wr_col != GRID_RSVD_COL)); // R4
    AST_CTRL_ROW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_row == CTRL_ROW) |-> (wr_col <= CTRL_LAST_COL)); // R5
    AST_NO_WR_WHILE_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !byte_vld); // R6
endmodule

// File: tb/tb_osd_i2c_sink.sv
module tb_osd_i2c_sink;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_drv = 1'b1;
    logic sda_oe, wr_en, wr_plane;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic [7:0] wr_data;
    wire  sda_line = sda_drv & ~sda_oe;

    always #2 clk = ~clk;

    osd_i2c_sink dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_plane(wr_plane),
        .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
    );

    localparam int H = 6;
    int checks = 0, errors = 0;
    bit done = 0;
    logic [17:0] expq[$];

    // behavioural model state
    int m_mode;   // 0 expect address, 1 addressed, 2 ignore
    int m_idx, m_row, m_col, m_plane;
    bit m_bad;

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compared every clock against the model's queue of expected writes
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (expq.size() == 0) begin
                chk(0, "R3/R4/R5 unexpected write", {wr_plane, wr_row, wr_col, wr_data}, 0);
            end else begin
                logic [17:0] e;
                e = expq.pop_front();
                chk({wr_plane, wr_row, wr_col, wr_data} == e, "R3 write fields",
                    {wr_plane, wr_row, wr_col, wr_data}, e);
            end
        end
    end

    task automatic i2c_start();
        sda_drv = 1; tick(H); scl = 1; tick(H); sda_drv = 0; tick(H); scl = 0; tick(H);
        m_mode = 0; m_idx = 0;
    endtask

    task automatic i2c_stop();
        sda_drv = 0; tick(H); scl = 1; tick(H); sda_drv = 1; tick(H);
        m_mode = 2;
    endtask

    task automatic put_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; tick(H); scl = 1; tick(H); scl = 0; tick(1);
        end
    endtask

    task automatic model_byte(logic [7:0] b);
        if (m_idx == 0) begin
            m_plane = b[7]; m_row = b[3:0]; m_bad = |b[6:4]; m_idx = 1;
        end else if (m_idx == 1) begin
            m_col = b[4:0]; m_bad = m_bad | (|b[7:5]); m_idx = 2;
        end else begin
            bit rs;
            rs = (m_row == 15) ? (m_col > 26) : (m_col == 30);
            if (!rs && !m_bad)
                expq.push_back({m_plane[0], m_row[3:0], m_col[4:0], b});
            m_col = (m_col + 1) % 32;
        end
    endtask

    task automatic put_byte(logic [7:0] b, string req);
        bit exp_ack;
        if (m_mode == 0) begin
            exp_ack = (b == 8'h7A); m_mode = exp_ack ? 1 : 2;
        end else if (m_mode == 1) begin
            exp_ack = 1; model_byte(b);
        end else begin
            exp_ack = 0;
        end
        put_bits(b, 8);
        sda_drv = 1; tick(H);
        chk(sda_oe == exp_ack, "R6 ack slot drive", sda_oe, exp_ack);
        scl = 1; tick(H / 2);
        chk(sda_line == !exp_ack, req, sda_line, !exp_ack);
        tick(H / 2); scl = 0; tick(H);
        chk(sda_oe == 0, "R6 released after ack", sda_oe, 0);
    endtask

    task automatic drained(string req);
        tick(4);
        chk(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        m_mode = 2; m_idx = 0; m_row = 0; m_col = 0; m_plane = 0; m_bad = 0;
        tick(5);
        chk(sda_oe == 0 && wr_en == 0, "R10 reset outputs", {sda_oe, wr_en}, 0);
        rst_n = 1; tick(5);

        // R2 R3 code plane
        i2c_start(); put_byte(8'h7A, "R1 ack address");
        put_byte(8'h03, "R2 row byte"); put_byte(8'h05, "R2 col byte");
        put_byte(8'h41, "R3 data"); put_byte(8'h42, "R3 data"); i2c_stop();
        drained("R3 all code writes seen");

        // R2 attribute plane, row attribute column 31
        i2c_start(); put_byte(8'h7A, "R1 ack address");
        put_byte(8'h87, "R2 plane bit"); put_byte(8'h1F, "R2 col byte");
        put_byte(8'h11, "R4 row attribute"); put_byte(8'h12, "R3 wrap to col 0");
        i2c_stop(); drained("R2 attribute writes seen");

        // R4 skip column 30 with wrap
        i2c_start(); put_byte(8'h7A, "R1 ack address");
        put_byte(8'h02, "R2"); put_byte(8'h1D, "R2");
        put_byte(8'hA0, "R4"); put_byte(8'hA1, "R4 col30 acked");
        put_byte(8'hA2, "R4"); put_byte(8'hA3, "R4"); i2c_stop();
        drained("R4 column 30 discarded, pointer advanced");

        // R5 control row
        i2c_start(); put_byte(8'h7A, "R1 ack address");
        put_byte(8'h0F, "R2"); put_byte(8'h19, "R2");
        for (int i = 0; i < 8; i++) put_byte(8'hC0 + 8'(i), "R5 control byte acked");
        i2c_stop(); drained("R5 control bank limits");

        // R1 read and foreign addresses
        i2c_start(); put_byte(8'h7B, "R1 read address not acked");
        put_byte(8'h01, "R1 ignored"); put_byte(8'h02, "R1 ignored");
        put_byte(8'h03, "R1 ignored"); i2c_stop();
        i2c_start(); put_byte(8'h70, "R1 other address not acked");
        put_byte(8'h01, "R1 ignored"); i2c_stop();
        drained("R1 no writes from unaddressed frames");

        // R9 out-of-range pointers
        i2c_start(); put_byte(8'h7A, "R1 ack address");
        put_byte(8'h13, "R9 bad row"); put_byte(8'h01, "R9");
        put_byte(8'h55, "R9 acked discarded"); i2c_stop();
        i2c_start(); put_byte(8'h7A, "R1 ack address");
        put_byte(8'h01, "R9"); put_byte(8'h21, "R9 bad col");
        put_byte(8'h56, "R9 acked discarded"); i2c_stop();
        drained("R9 out-of-range discarded");

        // R7 aborts
        i2c_start(); put_byte(8'h7A, "R1 ack address");
        put_byte(8'h01, "R2"); put_byte(8'h01, "R2");
        put_byte(8'h66, "R7 whole byte"); put_bits(8'h67, 4); i2c_stop();
        drained("R7 stop mid-byte no write");
        i2c_start(); put_byte(8'h7A, "R1 ack address");
        put_byte(8'h01, "R2"); put_byte(8'h02, "R2"); put_bits(8'h68, 5);
        i2c_start(); put_byte(8'h7A, "R7 restart after start abort");
        put_byte(8'h09, "R2"); put_byte(8'h09, "R2"); put_byte(8'h69, "R7");
        i2c_stop(); drained("R7 start mid-byte no write");

        // R8 repeated start
        i2c_start(); put_byte(8'h7A, "R1 ack address");
        put_byte(8'h04, "R2"); put_byte(8'h0A, "R2"); put_byte(8'h99, "R8");
        i2c_start(); put_byte(8'h7A, "R8 readdressed");
        put_byte(8'h06, "R8 new row"); put_byte(8'h02, "R8 new col");
        put_byte(8'h77, "R8"); i2c_start(); put_byte(8'h7B, "R8 read after restart");
        put_byte(8'h01, "R8 ignored"); i2c_stop();
        drained("R8 pointer reset by repeated start");

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule